// File: doc/BRIEF.md
# Overcurrent Limiter with Frequency Foldback

This block is the digital current-limit controller of a switching converter's PWM path. Each accepted current-sense sample, given in millivolts, is sorted into one of three zones: normal, moderate overload or severe overload. A saturating control accumulator then moves according to the zone. It recharges by a fixed step while the current is normal. Under moderate overload it discharges in proportion to how far the sample exceeds the lower threshold. Under severe overload it collapses by a large fixed step toward a zero clamp.

The accumulator sets three limits for the PWM generator: a duty-cycle ceiling, a frequency divide factor and a driver-disable flag. As the accumulator falls, the duty ceiling drops first. Only once the ceiling has reached its minimum does the switching frequency divide down, in steps, to one fifth of nominal. At the zero clamp both primary drivers are disabled. A normal sample returns the block to voltage mode at once. The accumulator then ramps back up from where it stands and does not restart a soft-start sequence.

Samples that arrive inside a short blanking window after a driver turn-on are ignored, so that switching spikes are not taken for overcurrent.

Top module: `ocl_limiter`

## Requirements
- R1: After reset the accumulator sits at its upper clamp (3072), `cur_mode` and `drv_off` are 0, `duty_ceil` is 236 and `fold_div` is 1.
- R2: An accepted sample below 100 mV adds 16 to the accumulator, saturating at 3072, and clears `cur_mode`.
- R3: An accepted sample from 100 to 150 mV inclusive sets `cur_mode` and lowers the accumulator by 4 × (sample − 100). The result never goes below 1, and an accumulator already at 0 stays at 0.
- R4: An accepted sample above 150 mV sets `cur_mode` and lowers the accumulator by 512, clamping at 0. `drv_off` is 1 exactly while the accumulator is 0.
- R5: While `cur_mode` is 1, `duty_ceil` is 13 for an accumulator of 1024 or less, 236 at 3072 or more, and 13 + ((acc − 1024) × 223) / 2048 (integer division) in between.
- R6: While `cur_mode` is 1, `fold_div` is 1 for an accumulator of 1024 or more and 5 − acc/256 below it, so it reaches 5 near zero. `fold_div` exceeds 1 only when `duty_ceil` is at its minimum.
- R7: While `cur_mode` is 0, `duty_ceil` is 236 and `fold_div` is 1. A normal sample gives this on the cycle after it is accepted. The accumulator then recharges from its present value, 16 per sample.
- R8: A valid sample in the cycle where `drv_rise` is 1, or in any of the 3 cycles after it, is ignored and changes no output.
- R9: A cycle with `sense_vld` at 0 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sense_mv | input | 10 | Current-sense sample in millivolts |
| sense_vld | input | 1 | Sample-valid strobe |
| drv_rise | input | 1 | Pulse marking a primary driver turn-on; opens the blanking window |
| duty_ceil | output | 8 | Duty-cycle ceiling, in 1/256 units |
| fold_div | output | 3 | Switching-frequency divide factor, 1 to 5 |
| cur_mode | output | 1 | 1 while current control owns the PWM |
| drv_off | output | 1 | 1 while both primary drivers must stay off |

## Verification
The assertions check several rules on every cycle. The ceiling and the divider stay in range. Voltage mode always presents the full ceiling with no division, and the frequency never divides before the ceiling bottoms out. The disable flag appears only under current control. A blanked or invalid cycle changes nothing. The exact accumulator arithmetic can be shown only by the bench's scenarios. These cover the proportional discharge rate, the floor at 1 in the moderate zone, the 512 collapse and the zero clamp, the 16-step recharge from wherever the accumulator stands, and the precise ceiling and divider values along the way, all of which the bench traces through its own model as the zones change.

// File: rtl/ocl_pkg.sv
package ocl_pkg;
  typedef enum logic [1:0] {
    ZONE_NORM   = 2'd0,
    ZONE_MOD    = 2'd1,
    ZONE_SEVERE = 2'd2
  } ocl_zone_e;
endpackage

// File: rtl/ocl_blank.sv
module ocl_blank #(
  parameter int BLANK_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sense_vld,
  input  logic drv_rise,
  output logic sample_take
);
  localparam int CNT_W = $clog2(BLANK_CYC + 1) + 1;
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(BLANK_CYC);

  logic [CNT_W-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      hold_cnt <= '0;
    else if (drv_rise)
      hold_cnt <= LOAD_V;
    else if (hold_cnt != '0)
      hold_cnt <= hold_cnt - 1'b1;
  end

  // R8: accept only outside the turn-on window
  assign sample_take = sense_vld && !drv_rise && (hold_cnt == '0);
endmodule

// File: rtl/ocl_integrator.sv
module ocl_integrator
  import ocl_pkg::*;
#(
  parameter int SENSE_W   = 10,
  parameter int ACC_W     = 12,
  parameter int ACC_HI    = 3072,
  parameter int TH_LO     = 100,
  parameter int TH_HI     = 150,
  parameter int UP_STEP   = 16,
  parameter int MOD_GAIN  = 4,
  parameter int FAST_STEP = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_take,
  input  logic [SENSE_W-1:0] sense_mv,
  output logic [ACC_W-1:0]   acc_q,
  output logic               cur_q,
  output ocl_zone_e          zone
);
  localparam int WW = ACC_W + 1;
  localparam logic [SENSE_W-1:0] TH_LO_V = SENSE_W'(TH_LO);
  localparam logic [SENSE_W-1:0] TH_HI_V = SENSE_W'(TH_HI);
  localparam logic [WW-1:0]      HI_W    = WW'(ACC_HI);
  localparam logic [WW-1:0]      UP_W    = WW'(UP_STEP);
  localparam logic [WW-1:0]      GAIN_W  = WW'(MOD_GAIN);
  localparam logic [WW-1:0]      FAST_W  = WW'(FAST_STEP);
  localparam logic [ACC_W-1:0]   HI_V    = ACC_W'(ACC_HI);
  localparam logic [ACC_W-1:0]   ONE_V   = ACC_W'(1);

  function automatic ocl_zone_e classify(input logic [SENSE_W-1:0] s);
    if (s < TH_LO_V)      return ZONE_NORM;
    else if (s > TH_HI_V) return ZONE_SEVERE;
    else                  return ZONE_MOD;
  endfunction

  function automatic logic [ACC_W-1:0] step_acc(input logic [ACC_W-1:0] a,
                                                input logic [SENSE_W-1:0] s,
                                                input ocl_zone_e z);
    logic [WW-1:0] wa, sum, dec;
    wa  = {1'b0, a};
    sum = wa + UP_W;
    dec = WW'(s - TH_LO_V) * GAIN_W;
    case (z)
      ZONE_NORM:   return (sum > HI_W) ? HI_V : sum[ACC_W-1:0];
      ZONE_MOD: begin
        if (a == '0)            return '0;
        else if (wa > dec + 1)  return a - dec[ACC_W-1:0];
        else                    return ONE_V;
      end
      default:     return (wa > FAST_W) ? a - FAST_W[ACC_W-1:0] : '0;
    endcase
  endfunction

  assign zone = classify(sense_mv);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= HI_V;
      cur_q <= 1'b0;
    end else if (sample_take) begin
      acc_q <= step_acc(acc_q, sense_mv, zone);
      cur_q <= (zone != ZONE_NORM);
    end
  end
endmodule

// File: rtl/ocl_shaper.sv
module ocl_shaper #(
  parameter int ACC_W    = 12,
  parameter int KNEE_SH  = 10,
  parameter int SPAN_SH  = 11,
  parameter int DUTY_W   = 8,
  parameter int DUTY_MAX = 236,
  parameter int DUTY_MIN = 13,
  parameter int FOLD_W   = 3
) (
  input  logic [ACC_W-1:0]  acc_q,
  input  logic              cur_q,
  output logic [DUTY_W-1:0] duty_ceil,
  output logic [FOLD_W-1:0] fold_div,
  output logic              drv_off
);
  localparam int KNEE   = 1 << KNEE_SH;
  localparam int ACC_HI = KNEE + (1 << SPAN_SH);
  localparam int PROD_W = SPAN_SH + DUTY_W + 1;
  localparam logic [ACC_W-1:0]  KNEE_V  = ACC_W'(KNEE);
  localparam logic [ACC_W-1:0]  HI_V    = ACC_W'(ACC_HI);
  localparam logic [DUTY_W-1:0] DMAX_V  = DUTY_W'(DUTY_MAX);
  localparam logic [DUTY_W-1:0] DMIN_V  = DUTY_W'(DUTY_MIN);
  localparam logic [PROD_W-1:0] DSPAN_V = PROD_W'(DUTY_MAX - DUTY_MIN);

  function automatic logic [DUTY_W-1:0] duty_of(input logic [ACC_W-1:0] a);
    logic [PROD_W-1:0] prod;
    prod = PROD_W'(a - KNEE_V) * DSPAN_V;
    if (a >= HI_V)        return DMAX_V;
    else if (a <= KNEE_V) return DMIN_V;
    else                  return DMIN_V + DUTY_W'(prod >> SPAN_SH);
  endfunction

  function automatic logic [FOLD_W-1:0] fold_of(input logic [ACC_W-1:0] a);
    logic [ACC_W-1:0] below;
    below = KNEE_V - ONE_A - a;
    if (a >= KNEE_V) return FOLD_W'(1);
    else             return FOLD_W'(2) + FOLD_W'(below >> (KNEE_SH - 2));
  endfunction

  localparam logic [ACC_W-1:0] ONE_A = ACC_W'(1);

  assign duty_ceil = cur_q ? duty_of(acc_q) : DMAX_V;
  assign fold_div  = cur_q ? fold_of(acc_q) : FOLD_W'(1);
  assign drv_off   = (acc_q == '0);
endmodule

// File: rtl/ocl_limiter.sv
module ocl_limiter
  import ocl_pkg::*;
#(
  parameter int SENSE_W   = 10,
  parameter int ACC_W     = 12,
  parameter int KNEE_SH   = 10,
  parameter int SPAN_SH   = 11,
  parameter int TH_LO     = 100,
  parameter int TH_HI     = 150,
  parameter int UP_STEP   = 16,
  parameter int MOD_GAIN  = 4,
  parameter int FAST_STEP = 512,
  parameter int DUTY_W    = 8,
  parameter int DUTY_MAX  = 236,
  parameter int DUTY_MIN  = 13,
  parameter int BLANK_CYC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SENSE_W-1:0] sense_mv,
  input  logic               sense_vld,
  input  logic               drv_rise,
  output logic [DUTY_W-1:0]  duty_ceil,
  output logic [2:0]         fold_div,
  output logic               cur_mode,
  output logic               drv_off
);
  localparam int ACC_HI = (1 << KNEE_SH) + (1 << SPAN_SH);

  logic             sample_take;
  logic [ACC_W-1:0] acc_q;
  ocl_zone_e        zone;

  ocl_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst_n(rst_n), .sense_vld(sense_vld),
    .drv_rise(drv_rise), .sample_take(sample_take)
  );

  ocl_integrator #(
    .SENSE_W(SENSE_W), .ACC_W(ACC_W), .ACC_HI(ACC_HI), .TH_LO(TH_LO),
    .TH_HI(TH_HI), .UP_STEP(UP_STEP), .MOD_GAIN(MOD_GAIN), .FAST_STEP(FAST_STEP)
  ) u_integ (
    .clk(clk), .rst_n(rst_n), .sample_take(sample_take), .sense_mv(sense_mv),
    .acc_q(acc_q), .cur_q(cur_mode), .zone(zone)
  );

  ocl_shaper #(
    .ACC_W(ACC_W), .KNEE_SH(KNEE_SH), .SPAN_SH(SPAN_SH), .DUTY_W(DUTY_W),
    .DUTY_MAX(DUTY_MAX), .DUTY_MIN(DUTY_MIN), .FOLD_W(3)
  ) u_shape (
    .acc_q(acc_q), .cur_q(cur_mode), .duty_ceil(duty_ceil),
    .fold_div(fold_div), .drv_off(drv_off)
  );
endmodule

// File: rtl/ocl_checks.sv
module ocl_checks #(
  parameter int DUTY_W   = 8,
  parameter int DUTY_MAX = 236,
  parameter int DUTY_MIN = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sense_vld,
  input logic              drv_rise,
  input logic              sample_take,
  input logic [DUTY_W-1:0] duty_ceil,
  input logic [2:0]        fold_div,
  input logic              cur_mode,
  input logic              drv_off
);
  // R7
  voltage_mode_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_mode |-> (duty_ceil == DUTY_W'(DUTY_MAX)) && (fold_div == 3'd1));

  // R5
  duty_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_ceil >= DUTY_W'(DUTY_MIN)) && (duty_ceil <= DUTY_W'(DUTY_MAX)));

  // R6
  fold_after_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_div > 3'd1) |-> (duty_ceil == DUTY_W'(DUTY_MIN)));

  // R6
  fold_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_div >= 3'd1) && (fold_div <= 3'd5));

  // R4
  off_needs_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_off |-> cur_mode);

  // R8
  blank_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_rise |-> !sample_take);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sense_vld |=> $stable(duty_ceil) && $stable(fold_div) &&
                   $stable(cur_mode) && $stable(drv_off));
endmodule

bind ocl_limiter ocl_checks #(
  .DUTY_W(DUTY_W), .DUTY_MAX(DUTY_MAX), .DUTY_MIN(DUTY_MIN)
) u_checks (
  .clk(clk), .rst_n(rst_n), .sense_vld(sense_vld), .drv_rise(drv_rise),
  .sample_take(sample_take), .duty_ceil(duty_ceil), .fold_div(fold_div),
  .cur_mode(cur_mode), .drv_off(drv_off)
);

// File: tb/sim_ocl_limiter.sv
module sim_ocl_limiter;
  localparam int BLK = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] sense_mv = '0;
  logic       sense_vld = 1'b0;
  logic       drv_rise = 1'b0;
  logic [7:0] duty_ceil;
  logic [2:0] fold_div;
  logic       cur_mode;
  logic       drv_off;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { int duty; int fold; int cur; int off; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  int m_acc = 3072;
  int m_cur = 0;
  int m_blank = 0;

  always #4 clk = ~clk;

  ocl_limiter u0 (
    .clk(clk), .rst_n(rst_n), .sense_mv(sense_mv), .sense_vld(sense_vld),
    .drv_rise(drv_rise), .duty_ceil(duty_ceil), .fold_div(fold_div),
    .cur_mode(cur_mode), .drv_off(drv_off)
  );

  function automatic int want_duty(int a, int c);
    if (c == 0 || a >= 3072) return 236;
    if (a <= 1024) return 13;
    return 13 + ((a - 1024) * 223) / 2048;
  endfunction

  function automatic int want_fold(int a, int c);
    if (c == 0 || a >= 1024) return 1;
    return 5 - a / 256;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, int s, bit r, string req);
    exp_t e;
    bit take;
    @(negedge clk);
    sense_vld = v; sense_mv = s[9:0]; drv_rise = r;
    @(posedge clk);
    take = v && !r && (m_blank == 0);
    if (r) m_blank = BLK;
    else if (m_blank > 0) m_blank--;
    if (take) begin
      if (s < 100) begin
        m_acc = m_acc + 16;
        if (m_acc > 3072) m_acc = 3072;
        m_cur = 0;
      end else if (s <= 150) begin
        if (m_acc != 0) begin
          m_acc = m_acc - (s - 100) * 4;
          if (m_acc < 1) m_acc = 1;
        end
        m_cur = 1;
      end else begin
        m_acc = m_acc - 512;
        if (m_acc < 0) m_acc = 0;
        m_cur = 1;
      end
    end
    e.duty = want_duty(m_acc, m_cur);
    e.fold = want_fold(m_acc, m_cur);
    e.cur  = m_cur;
    e.off  = (m_acc == 0) ? 1 : 0;
    exp_q.push_back(e);
    tag_q.push_back(req);
  endtask

  always @(posedge clk) begin
    #2;
    while (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, "duty_ceil", int'(duty_ceil), e.duty);
      chk(t, "fold_div",  int'(fold_div),  e.fold);
      chk(t, "cur_mode",  int'(cur_mode),  e.cur);
      chk(t, "drv_off",   int'(drv_off),   e.off);
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "duty_ceil", int'(duty_ceil), 236);
    chk("R1", "fold_div",  int'(fold_div),  1);
    chk("R1", "cur_mode",  int'(cur_mode),  0);
    chk("R1", "drv_off",   int'(drv_off),   0);

    for (int i = 0; i < 3; i++) step(1, 40, 0, "R2");
    for (int i = 0; i < 10; i++) step(1, 150, 0, "R3");
    step(1, 137, 0, "R5");
    for (int i = 0; i < 7; i++) step(1, 150, 0, "R6");
    step(1, 120, 0, "R3");
    step(1, 200, 0, "R4");
    step(1, 130, 0, "R4");
    step(0, 200, 0, "R9");
    step(1, 20, 0, "R7");
    step(1, 20, 0, "R7");
    step(1, 110, 0, "R5");
    for (int i = 0; i < 200; i++) step(1, 0, 0, "R2");
    step(1, 151, 0, "R4");
    step(1, 101, 0, "R3");
    step(1, 200, 1, "R8");
    for (int i = 0; i < BLK; i++) step(1, 200, 0, "R8");
    step(1, 200, 0, "R8");
    step(0, 40, 0, "R9");
    step(1, 150, 0, "R5");
    step(1, 60, 0, "R7");
    step(0, 0, 0, "R9");
    repeat (2) @(posedge clk);
    #3;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule